// File: doc/BRIEF.md
# I2C Control-Register Slave with Deferred Commit

This block is a two-wire bus slave that gives a bus master access to a small bank of 8-bit control registers. The SCL and SDA inputs arrive already synchronized to the system clock. Each one passes through a filter that ignores any level shorter than a set number of clocks. Start, repeated-start and stop conditions are decoded from the filtered lines. The slave answers to one fixed 7-bit device address and pulls SDA low through an open-drain enable.

A write carries a sub-address byte and then one or more data bytes, and the sub-address advances by one after each data byte. Written bytes go into a pending copy of the register bank. The register outputs change only when the master ends the transfer with a stop condition. To read, the master writes the sub-address, sends a repeated start and then the read address. The slave then returns register contents, or an external status byte for sub-addresses past the end of the bank. An undervoltage reset input returns the whole interface to its power-on state.

Top module: `i2c_shadow_regslave`

## Requirements
- R1: After reset, register i holds the value i*0x11 (modulo 256), the interface is idle and `sda_oe` is 0.
- R2: A level on SCL or SDA that lasts fewer than FILT_N system clocks (default 3) has no effect. This holds both for an extra SCL pulse during the low phase and for an SDA dip during the high phase.
- R3: The address byte 0x68 (write) or 0x69 (read) is acknowledged. These are the device address 0110100 followed by the R/W bit in bit 0, where 1 means read. Any other address byte is not acknowledged, and the slave then leaves SDA released for every later byte until the next start or stop.
- R4: In a write, the slave acknowledges the address byte, the sub-address byte and each data byte. It holds SDA low for the whole high phase of the ninth clock.
- R5: Each complete data byte goes into a pending entry at the current sub-address, and the sub-address then advances by one. The register outputs, and the values returned by reads, do not change before a stop.
- R6: A stop copies every pending entry into the active registers. A byte cut short by a start or stop is discarded. Pending entries survive a repeated start and are committed by the stop that follows.
- R7: After a repeated start with address 0x69, the slave acknowledges and sends the active register at the current sub-address, MSB first. It changes SDA only while SCL is low, and it sends `status_in` when the sub-address is NUM_REGS or higher.
- R8: In a read, if the master acknowledges a byte, the next byte comes from the sub-address plus one. If the master does not acknowledge, the slave releases SDA until the next start or stop.
- R9: A write to a sub-address of NUM_REGS or higher is acknowledged but changes no register.
- R10: Asserting `uv_rst` aborts any transfer, drops all pending entries and restores the R1 state. A later stop then commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| uv_rst | input | 1 | Undervoltage reset, synchronous, active high |
| scl_in | input | 1 | Bus clock line, synchronized |
| sda_in | input | 1 | Bus data line, synchronized |
| status_in | input | 8 | Byte returned for reads past the register bank |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | Active registers, register i in bits [8i+7:8i] |

## Verification
The bench stops a write with a stop condition four bits into a data byte. A design that stored partial bytes would corrupt the next register. It also reads back after a repeated start with data still pending. This exposes designs that leak pending bytes into reads, or that do not advance the sub-address. Two-clock pulses on SCL and SDA during a byte would, if they got through the filter, shift in extra bits or create a false start. Other tests cover a foreign address, a read the master does not acknowledge, and an undervoltage reset in the middle of a write. These catch a slave that keeps driving the bus or keeps stale pending data.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [6:0] DEV_ADDR_DEF = 7'b0110100;
    localparam int         NUM_REGS_DEF = 8;
    localparam int         FILT_N_DEF   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } st_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_ev_t;

    function automatic logic [7:0] reg_default(input int idx);
        return 8'(idx * 17);
    endfunction

endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
    parameter int FILT_N = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_N + 1);

    logic [CW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= 1'b1;
            cnt   <= '0;
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (din == dout) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_N - 1)) begin
                dout <= din;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: output only moves toward a level the input already held
    p_filter_follow_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        !$stable(dout) |-> ($past(din) == dout));

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start    = scl_f && scl_q && sda_q && !sda_f;
        ev.stop     = scl_f && scl_q && !sda_q && sda_f;
        ev.scl_rise = scl_f && !scl_q;
        ev.scl_fall = !scl_f && scl_q;
    end

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
    import i2cs_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  commit,
    input  logic [7:0]            rd_addr,
    input  logic [7:0]            status_in,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [7:0] act  [NUM_REGS];
    logic [7:0] pend [NUM_REGS];
    logic       pv   [NUM_REGS];
    logic       armed;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                act[g]  <= reg_default(g);
                pend[g] <= '0;
                pv[g]   <= 1'b0;
            end else begin
                if (commit) begin
                    if (pv[g]) act[g] <= pend[g];
                    pv[g] <= 1'b0;
                end
                if (wr_en && (wr_addr == 8'(g))) begin
                    pend[g] <= wr_data;
                    pv[g]   <= 1'b1;
                end
            end
        end
        assign regs_o[g*8 +: 8] = act[g];
    end

    assign rd_data = (rd_addr < 8'(NUM_REGS)) ? act[rd_addr[IW-1:0]] : status_in;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R5: active set is frozen except right after a commit
    p_hold_until_stop_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(commit) |-> $stable(regs_o));

endmodule

// File: rtl/i2c_shadow_regslave.sv
module i2c_shadow_regslave
    import i2cs_pkg::*;
#(
    parameter int         NUM_REGS = NUM_REGS_DEF,
    parameter int         FILT_N   = FILT_N_DEF,
    parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  uv_rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [7:0]            status_in,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic       rst_any;
    logic       scl_f, sda_f;
    bus_ev_t    ev;
    st_t        st;
    logic [3:0] bitcnt;
    logic [7:0] shreg, sub, txb, rd_data, rd_addr;
    logic       rw, mnack, wr_en;

    assign rst_any = rst | uv_rst;

    i2cs_glitch_filter #(.FILT_N(FILT_N)) u_scl_filt (
        .clk(clk), .rst(rst_any), .din(scl_in), .dout(scl_f));
    i2cs_glitch_filter #(.FILT_N(FILT_N)) u_sda_filt (
        .clk(clk), .rst(rst_any), .din(sda_in), .dout(sda_f));

    i2cs_bus_events u_events (
        .clk(clk), .rst(rst_any), .scl_f(scl_f), .sda_f(sda_f), .ev(ev));

    assign wr_en   = (st == ST_WDATA) && ev.scl_fall && (bitcnt == 4'd8);
    assign rd_addr = (st == ST_RDATA) ? sub + 8'd1 : sub;

    i2cs_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst_any), .wr_en(wr_en), .wr_addr(sub), .wr_data(shreg),
        .commit(ev.stop), .rd_addr(rd_addr), .status_in(status_in),
        .rd_data(rd_data), .regs_o(regs_o));

    always_ff @(posedge clk) begin
        if (rst_any) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            sub    <= '0;
            txb    <= '0;
            rw     <= 1'b0;
            mnack  <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.scl_rise) begin
            if ((st inside {ST_ADDR, ST_SUB, ST_WDATA}) && bitcnt < 4'd8) begin
                shreg  <= {shreg[6:0], sda_f};
                bitcnt <= bitcnt + 4'd1;
            end else if (st == ST_RDATA && bitcnt < 4'd9) begin
                if (bitcnt == 4'd8) mnack <= sda_f;
                bitcnt <= bitcnt + 4'd1;
            end
        end else if (ev.scl_fall) begin
            case (st)
                ST_ADDR: begin
                    if (bitcnt == 4'd8) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                            sda_oe <= 1'b1;
                            rw     <= shreg[0];
                            bitcnt <= 4'd9;
                        end else begin
                            st <= ST_IGNORE;
                        end
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (rw) begin
                            st     <= ST_RDATA;
                            txb    <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            st     <= ST_SUB;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_SUB, ST_WDATA: begin
                    if (bitcnt == 4'd8) begin
                        sub    <= (st == ST_SUB) ? shreg : sub + 8'd1;
                        sda_oe <= 1'b1;
                        bitcnt <= 4'd9;
                    end else if (bitcnt == 4'd9) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        st     <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                        sda_oe <= ~txb[3'(4'd7 - bitcnt)];
                    end else if (bitcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                    end else if (bitcnt == 4'd9) begin
                        if (mnack) begin
                            st <= ST_IGNORE;
                        end else begin
                            sub    <= sub + 8'd1;
                            txb    <= rd_data;
                            sda_oe <= ~rd_data[7];
                            bitcnt <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic                  armed;
    logic [NUM_REGS*8-1:0] dflt;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dflt
        assign dflt[g*8 +: 8] = reg_default(g);
    end

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R7: SDA is moved only while SCL is low (R4 ack drive included)
    p_sda_moves_low_r7: assert property (@(posedge clk) disable iff (rst_any || !armed)
        (!$stable(sda_oe) && !$past(ev.start) && !$past(ev.stop) && !$past(uv_rst))
        |-> !$past(scl_f));

    // R3: a slave that is not addressed keeps SDA released
    p_ignore_released_r3: assert property (@(posedge clk) disable iff (rst_any || !armed)
        (st == ST_IGNORE) |-> !sda_oe);

    // R6: a stop returns the interface to idle with SDA released
    p_stop_idle_r6: assert property (@(posedge clk) disable iff (rst_any || !armed)
        $past(ev.stop) |-> (st == ST_IDLE && !sda_oe));

    // R10: undervoltage reset restores default registers and releases SDA
    p_uv_defaults_r10: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(uv_rst) |-> (regs_o == dflt && !sda_oe));

endmodule

// File: tb/i2c_shadow_regslave_tb.sv
module i2c_shadow_regslave_tb;
    localparam int NR = 8;
    localparam int H  = 16;
    localparam int Q  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          uv_rst = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic [7:0]    status_in = 8'h00;
    logic          sda_oe;
    logic [NR*8-1:0] regs_o;
    logic          sda_line;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_r [NR];

    assign sda_line = sda_m & ~sda_oe;

    i2c_shadow_regslave u_dut (
        .clk(clk), .rst(rst), .uv_rst(uv_rst), .scl_in(scl_m), .sda_in(sda_line),
        .status_in(status_in), .sda_oe(sda_oe), .regs_o(regs_o));

    always #2 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NR; i++)
            check(regs_o[i*8 +: 8] == exp_r[i], req, 32'(regs_o[i*8 +: 8]), 32'(exp_r[i]));
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    // send the top n bits of b; glitch adds short SCL/SDA pulses
    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i >= 8 - n; i--) begin
            sda_m = b[i];
            if (glitch) begin
                tick(2); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q - 4);
                scl_m = 1'b1; tick(4);
                if (b[i]) begin sda_m = 1'b0; tick(2); sda_m = 1'b1; tick(H - 6); end
                else tick(H - 4);
            end else begin
                tick(Q); scl_m = 1'b1; tick(H);
            end
            scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        logic a0, a1;
        send_bits(b, 8, glitch);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(1); a0 = sda_line;
        tick(H - 2); a1 = sda_line; tick(1);
        scl_m = 1'b0; tick(Q);
        acked = !a0 && !a1;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b, output bit steady);
        logic s0, s1;
        steady = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(1); s0 = sda_line;
            tick(H - 2); s1 = sda_line; tick(1);
            scl_m = 1'b0; b[i] = s0;
            if (s0 != s1) steady = 1'b0;
            tick(Q);
        end
        sda_m = ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_hdr(input logic [7:0] sa, input string req);
        bit ak;
        bus_start();
        send_byte(8'h68, 0, ak); check(ak, req, 32'(ak), 1);
        send_byte(sa, 0, ak);    check(ak, req, 32'(ak), 1);
    endtask

    task automatic read_one(input logic [7:0] sa, input logic [7:0] expv, input string req);
        bit ak, st;
        logic [7:0] d;
        write_hdr(sa, req);
        bus_start();
        send_byte(8'h69, 0, ak); check(ak, req, 32'(ak), 1);
        recv_byte(0, d, st);
        check(d == expv, req, 32'(d), 32'(expv));
        check(st, req, 32'(st), 1);
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R1", 32'(sda_oe), 0);
        check_regs("R1");
    endtask

    task automatic t_write_commit();
        bit ak;
        write_hdr(8'h02, "R4");
        send_byte(8'hA5, 0, ak); check(ak, "R4", 32'(ak), 1);
        send_byte(8'h5C, 0, ak); check(ak, "R4", 32'(ak), 1);
        check_regs("R5");
        bus_stop(); tick(4);
        exp_r[2] = 8'hA5; exp_r[3] = 8'h5C;
        check_regs("R6");
    endtask

    task automatic t_wrong_addr();
        bit ak;
        bus_start();
        send_byte(8'h6A, 0, ak); check(!ak, "R3", 32'(ak), 0);
        send_byte(8'h00, 0, ak); check(!ak, "R3", 32'(ak), 0);
        send_byte(8'h11, 0, ak); check(!ak, "R3", 32'(ak), 0);
        bus_stop(); tick(4);
        check_regs("R3");
    endtask

    task automatic t_read();
        bit ak, st;
        logic [7:0] d;
        read_one(8'h03, 8'h5C, "R7");
        write_hdr(8'h02, "R8");
        bus_start();
        send_byte(8'h69, 0, ak); check(ak, "R8", 32'(ak), 1);
        recv_byte(1, d, st); check(d == 8'hA5, "R8", 32'(d), 32'hA5);
        recv_byte(0, d, st); check(d == 8'h5C, "R8", 32'(d), 32'h5C);
        recv_byte(0, d, st); check(d == 8'hFF, "R8", 32'(d), 32'hFF);
        bus_stop();
    endtask

    task automatic t_status();
        status_in = 8'h3E;
        read_one(8'h40, 8'h3E, "R7");
    endtask

    task automatic t_partial();
        bit ak;
        write_hdr(8'h04, "R6");
        send_byte(8'h3C, 0, ak); check(ak, "R6", 32'(ak), 1);
        send_bits(8'hF0, 4, 0);
        bus_stop(); tick(4);
        exp_r[4] = 8'h3C;
        check_regs("R6");
    endtask

    task automatic t_pending_rstart();
        bit ak, st;
        logic [7:0] d;
        write_hdr(8'h06, "R5");
        send_byte(8'h99, 0, ak); check(ak, "R5", 32'(ak), 1);
        bus_start();
        send_byte(8'h69, 0, ak); check(ak, "R5", 32'(ak), 1);
        recv_byte(0, d, st); check(d == exp_r[7], "R5", 32'(d), 32'(exp_r[7]));
        check_regs("R5");
        bus_stop(); tick(4);
        exp_r[6] = 8'h99;
        check_regs("R6");
    endtask

    task automatic t_oob_write();
        bit ak;
        status_in = 8'hC3;
        write_hdr(8'h09, "R9");
        send_byte(8'h12, 0, ak); check(ak, "R9", 32'(ak), 1);
        bus_stop(); tick(4);
        check_regs("R9");
        read_one(8'h09, 8'hC3, "R9");
    endtask

    task automatic t_glitch();
        bit ak;
        write_hdr(8'h01, "R2");
        send_byte(8'h42, 1, ak); check(ak, "R2", 32'(ak), 1);
        bus_stop(); tick(4);
        exp_r[1] = 8'h42;
        check_regs("R2");
    endtask

    task automatic t_uv();
        bit ak;
        write_hdr(8'h00, "R10");
        send_byte(8'hEE, 0, ak); check(ak, "R10", 32'(ak), 1);
        uv_rst = 1'b1; tick(1); uv_rst = 1'b0; tick(1);
        for (int i = 0; i < NR; i++) exp_r[i] = 8'(i * 17);
        check(sda_oe == 1'b0, "R10", 32'(sda_oe), 0);
        check_regs("R10");
        bus_stop(); tick(4);
        check_regs("R10");
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < NR; i++) exp_r[i] = 8'(i * 17);
        tick(5); rst = 1'b0; tick(5);
        t_reset();
        t_write_commit();
        t_wrong_addr();
        t_read();
        t_status();
        t_partial();
        t_pending_rstart();
        t_oob_write();
        t_glitch();
        t_uv();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule